// File: doc/BRIEF.md
# Peripheral Interrupt Request Controller

This block is the interrupt front end for one event source of a serial port. A transmitter and a receiver each use their own instance. Software programs two byte-wide registers through a simple register bus. The control register holds a priority level, a vector-mode bit and a pending flag. The vector register holds the number that is returned in vectored mode. A one-cycle event pulse from the serial logic sets the pending flag. While the flag is set and the level is nonzero, the block presents that level to the CPU as its request.

When the CPU runs an acknowledge cycle at a level, the matching instance replies on the next clock edge with a one-cycle strobe. In autovector mode the strobe tells the CPU to take the vector from its own fixed table. In vectored mode a vector-valid strobe is raised together with the 8-bit vector number. The same reply clears the pending flag. Software can also clear the flag by writing 0 to it. A hardware event in the same cycle as any clear wins, so no event is lost.

The ports carry no flow control. Register writes take effect in one cycle, and the acknowledge reply is a single-cycle strobe with no back-pressure. This fits the fixed timing of the CPU acknowledge cycle.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset, the control register (address 0) and the vector register (address 1) both read 0x00, irq_level_o is 0, and both reply strobes are low.
- R2: Control register layout: bit 5 is the vector mode (1 = vectored), bit 3 is pending, and bits 2:0 are the priority level. Bits 7, 6 and 4 read 0, and writes to them are ignored. The vector register reads back the full byte that was written. Writes take effect at the next clock edge, and read data follows reg_addr_i without delay.
- R3: An event_i pulse sets pending at the next edge. While pending is set and the level is nonzero, irq_level_o equals the programmed level.
- R4: A level of 0 masks the source: irq_level_o is 0 even while pending is set.
- R5: Writing the control register with bit 3 = 0 clears pending. Writing bit 3 = 1 never sets pending.
- R6: An event in the same cycle as a software clear or an acknowledge clear leaves pending set.
- R7: iack_i with iack_level_i equal to a nonzero programmed level, while pending is set, produces a reply strobe for exactly one cycle after that edge and clears pending.
- R8: With mode 0 the reply is autovec_o = 1, vec_valid_o = 0 and vec_o = 0x00. With mode 1 the reply is vec_valid_o = 1, autovec_o = 0 and vec_o equal to the vector register.
- R9: An acknowledge at a different level, or while pending is clear, produces no strobe and leaves pending unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| event_i | input | 1 | Interrupt event pulse from the serial logic |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 selects control, 1 selects vector |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| irq_level_o | output | 3 | Requested priority level, 0 when there is no request |
| iack_i | input | 1 | CPU acknowledge cycle strobe |
| iack_level_i | input | 3 | Level being acknowledged |
| autovec_o | output | 1 | Reply: use the autovector |
| vec_valid_o | output | 1 | Reply: vec_o carries the vector |
| vec_o | output | 8 | Vector number |

## Verification
The assertions assume that every input is a known value from the first edge after reset. They also assume that iack_i is a single-cycle strobe carrying a level that is valid in that cycle, and that event_i is sampled only at clock edges. The stimulus changes inputs only on the falling edge, drops every strobe after one cycle, and holds iack_i low during reset. It never issues two acknowledges back to back. The reply of one acknowledge is therefore always observed before the next one begins.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W   = 8;
  localparam int LVL_W    = 3;
  localparam int ADDR_W   = 1;
  localparam int MODE_BIT = 5;
  localparam int PEND_BIT = 3;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 1'b0;
  localparam logic [ADDR_W-1:0] VEC_ADDR  = 1'b1;

  typedef struct packed {
    logic             mode;
    logic [LVL_W-1:0] level;
  } ctrl_t;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pending_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] vector_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic unused_rsvd;
  assign unused_rsvd = ^{wdata_i[DATA_W-1:MODE_BIT+1], wdata_i[PEND_BIT+1], wdata_i[PEND_BIT]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_o   <= '0;
      vector_o <= '0;
    end else if (wr_i) begin
      if (addr_i == CTRL_ADDR) begin
        ctrl_o.mode  <= wdata_i[MODE_BIT];
        ctrl_o.level <= wdata_i[LVL_W-1:0];
      end else begin
        vector_o <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_ADDR) begin
      rdata_o[MODE_BIT]    = ctrl_o.mode;
      rdata_o[PEND_BIT]    = pending_i;
      rdata_o[LVL_W-1:0]   = ctrl_o.level;
    end else begin
      rdata_o = vector_o;
    end
  end

  // R2: a write to the vector register lands unchanged
  p_vec_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == VEC_ADDR) |=> (vector_o == $past(wdata_i)));
endmodule

// File: rtl/irq_pending.sv
module irq_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  input  logic sw_clr_i,
  input  logic ack_clr_i,
  output logic pending_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                    pending_o <= 1'b0;
    else if (event_i)              pending_o <= 1'b1;
    else if (sw_clr_i || ack_clr_i) pending_o <= 1'b0;
  end

  p_event_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    event_i |=> pending_o);
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr_i && !event_i) |=> !pending_o);
  p_no_sw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_o && !event_i) |=> !pending_o);
endmodule

// File: rtl/irq_ack.sv
module irq_ack
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iack_i,
  input  logic [LVL_W-1:0]  iack_level_i,
  input  logic              pending_i,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] vector_i,
  output logic              hit_o,
  output logic              autovec_o,
  output logic              vec_valid_o,
  output logic [DATA_W-1:0] vec_o
);
  assign hit_o = iack_i && pending_i && (ctrl_i.level != '0) && (iack_level_i == ctrl_i.level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      autovec_o   <= 1'b0;
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
    end else begin
      autovec_o   <= hit_o && !ctrl_i.mode;
      vec_valid_o <= hit_o && ctrl_i.mode;
      vec_o       <= (hit_o && ctrl_i.mode) ? vector_i : '0;
    end
  end

  p_one_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(autovec_o && vec_valid_o));
  p_reply_needs_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (autovec_o || vec_valid_o) |-> $past(iack_i));
  p_wrong_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_i && iack_level_i != ctrl_i.level) |=> !(autovec_o || vec_valid_o));
  p_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (autovec_o || vec_valid_o) |=> !(autovec_o || vec_valid_o));
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              event_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [LVL_W-1:0]  irq_level_o,
  input  logic              iack_i,
  input  logic [LVL_W-1:0]  iack_level_i,
  output logic              autovec_o,
  output logic              vec_valid_o,
  output logic [DATA_W-1:0] vec_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] vector;
  logic              pending;
  logic              sw_clr;
  logic              hit;

  assign sw_clr = reg_wr_i && (reg_addr_i == CTRL_ADDR) && !reg_wdata_i[PEND_BIT];

  irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .pending_i(pending), .ctrl_o(ctrl),
    .vector_o(vector), .rdata_o(reg_rdata_o)
  );

  irq_pending u_pend (
    .clk(clk), .rst_n(rst_n), .event_i(event_i), .sw_clr_i(sw_clr),
    .ack_clr_i(hit), .pending_o(pending)
  );

  irq_ack u_ack (
    .clk(clk), .rst_n(rst_n), .iack_i(iack_i), .iack_level_i(iack_level_i),
    .pending_i(pending), .ctrl_i(ctrl), .vector_i(vector), .hit_o(hit),
    .autovec_o(autovec_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o)
  );

  assign irq_level_o = pending ? ctrl.level : '0;

  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.level == '0) |-> (irq_level_o == '0));
  p_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(event_i) |-> (irq_level_o == ctrl.level));
endmodule

// File: tb/irq_src_ctrl_tb.sv
module irq_src_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       event_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [0:0] reg_addr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [2:0] irq_level_o;
  logic       iack_i = 1'b0;
  logic [2:0] iack_level_i = '0;
  logic       autovec_o, vec_valid_o;
  logic [7:0] vec_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_src_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .event_i(event_i), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .irq_level_o(irq_level_o), .iack_i(iack_i), .iack_level_i(iack_level_i),
    .autovec_o(autovec_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk); reg_wr_i = 0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    reg_addr_i = a; #1 d = reg_rdata_o;
  endtask

  task automatic pulse_event();
    @(negedge clk); event_i = 1;
    @(negedge clk); event_i = 0;
  endtask

  task automatic ack(logic [2:0] lvl);
    @(negedge clk); iack_i = 1; iack_level_i = lvl;
    @(negedge clk); iack_i = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(0, d); check("R1 ctrl", d, 8'h00);
    rd(1, d); check("R1 vector", d, 8'h00);
    check("R1 level", {5'b0, irq_level_o}, 8'h00);
    check("R1 strobes", {6'b0, autovec_o, vec_valid_o}, 8'h00);
  endtask

  task automatic t_fields();
    logic [7:0] d;
    wr(0, 8'hFF); rd(0, d); check("R2 R5 reserved/pend", d, 8'h27);
    check("R5 no sw set", {5'b0, irq_level_o}, 8'h00);
    wr(1, 8'hA5); rd(1, d); check("R2 vector", d, 8'hA5);
  endtask

  task automatic t_event_mask();
    logic [7:0] d;
    wr(0, 8'h05); pulse_event();
    rd(0, d); check("R3 pending", d, 8'h0D);
    check("R3 level", {5'b0, irq_level_o}, 8'h05);
    wr(0, 8'h08); rd(0, d); check("R4 ctrl", d, 8'h08);
    check("R4 masked", {5'b0, irq_level_o}, 8'h00);
    wr(0, 8'h0D); check("R3 unmasked", {5'b0, irq_level_o}, 8'h05);
    wr(0, 8'h05); rd(0, d); check("R5 sw clear", d, 8'h05);
    check("R5 no request", {5'b0, irq_level_o}, 8'h00);
  endtask

  task automatic t_race();
    logic [7:0] d;
    @(negedge clk); event_i = 1; reg_wr_i = 1; reg_addr_i = 0; reg_wdata_i = 8'h05;
    @(negedge clk); event_i = 0; reg_wr_i = 0;
    rd(0, d); check("R6 event beats sw clear", d, 8'h0D);
    @(negedge clk); event_i = 1; iack_i = 1; iack_level_i = 3'd5;
    @(negedge clk); event_i = 0; iack_i = 0;
    check("R6 reply", {7'b0, autovec_o}, 8'h01);
    rd(0, d); check("R6 event beats ack", d, 8'h0D);
  endtask

  task automatic t_ack_auto();
    logic [7:0] d;
    ack(3'd3);
    check("R9 wrong level", {6'b0, autovec_o, vec_valid_o}, 8'h00);
    rd(0, d); check("R9 pending kept", d, 8'h0D);
    ack(3'd5);
    check("R8 autovec", {6'b0, autovec_o, vec_valid_o}, 8'h02);
    check("R8 vec zero", vec_o, 8'h00);
    rd(0, d); check("R7 cleared", d, 8'h05);
    check("R7 no request", {5'b0, irq_level_o}, 8'h00);
    @(negedge clk); check("R7 one cycle", {6'b0, autovec_o, vec_valid_o}, 8'h00);
  endtask

  task automatic t_ack_vec();
    logic [7:0] d;
    wr(0, 8'h22); wr(1, 8'h5C); pulse_event();
    check("R3 level2", {5'b0, irq_level_o}, 8'h02);
    ack(3'd2);
    check("R8 vec_valid", {6'b0, autovec_o, vec_valid_o}, 8'h01);
    check("R8 vector", vec_o, 8'h5C);
    rd(0, d); check("R7 cleared vec", d, 8'h22);
    ack(3'd2);
    check("R9 not pending", {6'b0, autovec_o, vec_valid_o}, 8'h00);
    rd(0, d); check("R9 still clear", d, 8'h22);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fields();
    t_event_mask();
    t_race();
    t_ack_auto();
    t_ack_vec();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule